// File: doc/BRIEF.md
# Write-Only Serial Control Register Slave

This block is a two-wire serial slave that only accepts writes. It loads a small bank of 8-bit control registers for a three-channel video preamplifier. A host first sends the device address, then a register index, then one or more data bytes. The block samples both bus lines with its own system clock, so it needs no clock from the bus. It presents every register as a parallel output, and downstream logic (gain, offset and mode control) reads those outputs directly.

SDA is modelled as an open-drain line. The input `sda_i` is the resolved state of the line. The output `sda_pull_o` is high whenever the block wants the line held low. A board or a testbench combines the two as a wired AND.

The registers are laid out as follows:
- Index 0 holds contrast.
- Index 1 holds brightness.
- Indices 2 to 4 hold the drive of channel 1, 2 and 3.
- Index 5 holds the on-screen-display level.
- Index 6 holds the DC output level.
- Index 7 is a spare byte.
- Index 8 holds the mode byte. Its bit 7 selects the blanking polarity: 1 means positive.

Top module: `vpa_ctl_slave`

## Requirements
- R1: An address byte of 0xDC is acknowledged. This is the device address 7'b1101110 with bit 0, the direction bit, equal to 0.
- R2: An address byte other than 0xDC or 0xDD is not acknowledged. No register changes until the next start condition.
- R3: An address byte of 0xDD (a read request) is not acknowledged. The slave never pulls SDA low during that transfer.
- R4: The slave pulls SDA low during the ninth clock after the address byte, after the register-index byte and after every data byte of a write.
- R5: Bytes are received MSB first. The first data byte lands in the register named by the index byte, and the new value appears on `regs_o[8*i +: 8]`.
- R6: Each further data byte before a stop goes to the next index (auto-increment).
- R7: A start condition in the middle of a transfer returns the slave to the address phase. The index byte that follows is the one that counts.
- R8: After reset every register reads 0x00, except index 8, which reads 0x80 (positive blanking).
- R9: A pulse on SCL shorter than FILT_LEN system clocks (4 by default) is filtered out and shifts no bit.
- R10: A data byte aimed at an index of 9 or above is acknowledged but changes no register.
- R11: After a stop condition, clock pulses that come without a new start condition are ignored and are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Resolved serial data line level |
| sda_pull_o | output | 1 | High to pull SDA low (acknowledge) |
| regs_o | output | NUM_REGS*8 | All register bytes, index i at bits 8*i+7 down to 8*i |

## Verification
Some properties are checked on every cycle:
- The data line is pulled only in an acknowledge state, and never while a read request is being ignored.
- A detected start always leads to the address phase.
- The filtered lines cannot change before the filter counter expires.
- Out-of-range writes leave every output register stable.
- The mode byte leaves reset as 0x80.

Other behaviours show only in the bench's bus-level scenarios:
- a value landing MSB first in the right register;
- auto-increment running across the end of the map;
- a repeated start discarding a half-finished index;
- a bus clock glitch failing to shift a bit;
- bits after a stop being ignored.

// File: rtl/vpa_ctl_pkg.sv
package vpa_ctl_pkg;
  localparam int BYTE_W = 8;
  localparam logic [6:0] DEV_ADDR7 = 7'b1101110;
  localparam logic [7:0] DEV_WR_BYTE = {DEV_ADDR7, 1'b0};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_INDEX,
    ST_ACK_INDEX,
    ST_DATA,
    ST_ACK_DATA,
    ST_IGNORE
  } xfer_state_t;
endpackage

// File: rtl/vpa_line_filter.sv
module vpa_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LIM = CW'(FILT_LEN - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] != filt_q) begin
        if (cnt_q == LIM) begin
          filt_q <= sync_q[1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign line_o = filt_q;

  // R9: the filtered level holds until the disagreement counter expires
  p_filter_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != LIM) |=> $stable(filt_q));
endmodule

// File: rtl/vpa_xfer_fsm.sv
module vpa_xfer_fsm
  import vpa_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_f,
  input  logic       sda_f,
  output logic       sda_pull_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o
);
  xfer_state_t state_q;
  logic       scl_q, sda_q;
  logic [7:0] sh_q;
  logic [3:0] bitcnt_q;
  logic [7:0] ptr_q;
  logic       start_det, stop_det, scl_rise, scl_fall, byte_done, in_byte;

  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign byte_done = scl_fall & (bitcnt_q == 4'd8);
  assign in_byte   = (state_q == ST_ADDR) | (state_q == ST_INDEX) | (state_q == ST_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      sh_q       <= '0;
      bitcnt_q   <= '0;
      ptr_q      <= '0;
      sda_pull_o <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_det) begin
        state_q    <= ST_ADDR;
        bitcnt_q   <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        state_q    <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        if (in_byte && scl_rise && bitcnt_q < 4'd8) begin
          sh_q     <= {sh_q[6:0], sda_f};
          bitcnt_q <= bitcnt_q + 1'b1;
        end
        case (state_q)
          ST_ADDR: if (byte_done) begin
            if (sh_q == DEV_WR_BYTE) begin
              sda_pull_o <= 1'b1;
              state_q    <= ST_ACK_ADDR;
            end else begin
              state_q <= ST_IGNORE;
            end
          end
          ST_INDEX: if (byte_done) begin
            ptr_q      <= sh_q;
            sda_pull_o <= 1'b1;
            state_q    <= ST_ACK_INDEX;
          end
          ST_DATA: if (byte_done) begin
            wr_en_o    <= 1'b1;
            wr_addr_o  <= ptr_q;
            wr_data_o  <= sh_q;
            ptr_q      <= ptr_q + 1'b1;
            sda_pull_o <= 1'b1;
            state_q    <= ST_ACK_DATA;
          end
          ST_ACK_ADDR, ST_ACK_INDEX, ST_ACK_DATA: if (scl_fall) begin
            sda_pull_o <= 1'b0;
            bitcnt_q   <= '0;
            state_q    <= (state_q == ST_ACK_ADDR) ? ST_INDEX : ST_DATA;
          end
          default: ;
        endcase
      end
    end
  end

  // R4: the line is only ever pulled inside an acknowledge slot
  p_pull_in_ack_r4: assert property (@(posedge clk) disable iff (rst)
    sda_pull_o |-> (state_q inside {ST_ACK_ADDR, ST_ACK_INDEX, ST_ACK_DATA}));
  // R3: an ignored transfer (read or foreign address) never drives SDA
  p_read_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IGNORE) |-> !sda_pull_o);
  // R7: any start, even mid-transfer, goes back to the address phase
  p_restart_addr_r7: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state_q == ST_ADDR) && !sda_pull_o);
  // R5: register writes originate only from a completed data byte
  p_write_from_data_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> ($past(state_q) == ST_DATA));
endmodule

// File: rtl/vpa_reg_bank.sv
module vpa_reg_bank #(
  parameter int          NUM_REGS   = 9,
  parameter int          MODE_IDX   = 8,
  parameter logic [7:0]  MODE_RESET = 8'h80
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] RST_VAL = (i == MODE_IDX) ? MODE_RESET : 8'h00;
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_o[i*8 +: 8] <= RST_VAL;
      end else if (wr_en && wr_addr == 8'(i)) begin
        regs_o[i*8 +: 8] <= wr_data;
      end
    end
  end

  // R8: mode byte leaves reset with positive blanking selected
  p_mode_reset_r8: assert property (@(posedge clk)
    rst |=> (regs_o[MODE_IDX*8 +: 8] == MODE_RESET));
  // R10: writes past the end of the map leave every register unchanged
  p_oob_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr >= 8'(NUM_REGS)) |=> $stable(regs_o));
endmodule

// File: rtl/vpa_ctl_slave.sv
module vpa_ctl_slave #(
  parameter int         NUM_REGS   = 9,
  parameter int         FILT_LEN   = 4,
  parameter int         MODE_IDX   = 8,
  parameter logic [7:0] MODE_RESET = 8'h80
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic       scl_f, sda_f;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data;

  vpa_line_filter #(.FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk(clk), .rst(rst), .line_i(scl_i), .line_o(scl_f));
  vpa_line_filter #(.FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk(clk), .rst(rst), .line_i(sda_i), .line_o(sda_f));

  vpa_xfer_fsm u_fsm (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .sda_pull_o(sda_pull_o), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data));

  vpa_reg_bank #(.NUM_REGS(NUM_REGS), .MODE_IDX(MODE_IDX), .MODE_RESET(MODE_RESET)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_o(regs_o));
endmodule

// File: tb/vpa_ctl_slave_tb.sv
module vpa_ctl_slave_tb_top;
  localparam int NR = 9;
  localparam int HP = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic sda_pull;
  logic [NR*8-1:0] regs;
  logic sda_line;
  logic [7:0] model [NR];
  int checks = 0, failures = 0, stray = 0;

  assign sda_line = sda_drv & ~sda_pull;

  always #10 clk = ~clk;

  vpa_ctl_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .regs_o(regs));

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wt(HP);
    scl_drv = 1'b1; wt(HP);
    sda_drv = 1'b0; wt(HP);
    scl_drv = 1'b0; wt(HP);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wt(HP);
    scl_drv = 1'b1; wt(HP);
    sda_drv = 1'b1; wt(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wt(HP);
      scl_drv = 1'b1; wt(HP/2);
      if (b[i] && !sda_line) stray++;
      wt(HP/2);
      scl_drv = 1'b0;
    end
    sda_drv = 1'b1; wt(HP);
    scl_drv = 1'b1; wt(HP/2);
    acked = !sda_line;
    wt(HP/2);
    scl_drv = 1'b0; wt(HP);
  endtask

  task automatic check_regs(input string req);
    wt(4);
    for (int i = 0; i < NR; i++)
      chk(regs[i*8 +: 8] == model[i], req, regs[i*8 +: 8], model[i]);
  endtask

  task automatic write_one(input int idx, input logic [7:0] v, input string req);
    bit a;
    bus_start();
    send_byte(8'hDC, a); chk(a, "R1 addr ack", a, 1);
    send_byte(8'(idx), a); chk(a, "R4 index ack", a, 1);
    send_byte(v, a);       chk(a, "R4 data ack", a, 1);
    bus_stop();
    if (idx < NR) model[idx] = v;
    check_regs(req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    bit a;
    logic [7:0] vals [3];
    wt(5); rst = 1'b0; wt(5);
    for (int i = 0; i < NR; i++) model[i] = (i == 8) ? 8'h80 : 8'h00;
    check_regs("R8 reset values");

    // R5 sweep: every index with several patterns (MSB-first landing)
    for (int i = 0; i < NR; i++) begin
      vals[0] = 8'hFF; vals[1] = 8'hA5; vals[2] = 8'(i * 17 + 3);
      for (int k = 0; k < 3; k++) write_one(i, vals[k], "R5 single write");
    end

    // R6 burst across whole map
    bus_start();
    send_byte(8'hDC, a); send_byte(8'h00, a);
    for (int i = 0; i < NR; i++) begin
      send_byte(8'(8'h30 + i), a); chk(a, "R6 burst ack", a, 1);
      model[i] = 8'(8'h30 + i);
    end
    bus_stop();
    check_regs("R6 auto-increment");

    // R6/R10 burst running past the end
    bus_start();
    send_byte(8'hDC, a); send_byte(8'h07, a);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    chk(a, "R10 past-end ack", a, 1);
    bus_stop();
    model[7] = 8'h11; model[8] = 8'h22;
    check_regs("R10 burst past end");

    // R10 out-of-range index
    write_one(8'h20, 8'h77, "R10 out of range");

    // R3 read request
    stray = 0;
    bus_start();
    send_byte(8'hDD, a); chk(!a, "R3 read nack", a, 0);
    send_byte(8'hFF, a); chk(!a, "R3 quiet", a, 0);
    send_byte(8'hFF, a);
    bus_stop();
    chk(stray == 0, "R3 no drive", stray, 0);
    check_regs("R3 no change");

    // R2 foreign address
    bus_start();
    send_byte(8'hA0, a); chk(!a, "R2 nack", a, 0);
    send_byte(8'h01, a); chk(!a, "R2 index ignored", a, 0);
    send_byte(8'h99, a);
    bus_stop();
    check_regs("R2 no change");

    // R7 repeated start
    bus_start();
    send_byte(8'hDC, a); send_byte(8'h03, a);
    bus_start();
    send_byte(8'hDC, a); chk(a, "R7 readdress ack", a, 1);
    send_byte(8'h05, a); send_byte(8'h5A, a);
    bus_stop();
    model[5] = 8'h5A;
    check_regs("R7 repeated start");

    // R9 short SCL glitch before the data byte
    bus_start();
    send_byte(8'hDC, a); send_byte(8'h02, a);
    sda_drv = 1'b0; wt(HP);
    scl_drv = 1'b1; wt(2); scl_drv = 1'b0; wt(HP);
    send_byte(8'h3C, a); chk(a, "R9 ack after glitch", a, 1);
    bus_stop();
    model[2] = 8'h3C;
    check_regs("R9 glitch filtered");

    // R11 bytes after a stop without start
    send_byte(8'hDC, a); chk(!a, "R11 no ack after stop", a, 0);
    send_byte(8'h00, a); send_byte(8'hEE, a);
    sda_drv = 1'b1; wt(HP);
    check_regs("R11 ignored after stop");

    chk(stray == 0, "R4 no stray pull", stray, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule